// File: doc/BRIEF.md
# Clock Generator Power and Sync State Controller

This block is the control core of a multi-output clock generator. It chooses one of four operating modes: normal, sync, sleep and power-down. It drives the enables of the PLL, of the output dividers and of the output buffers to match the mode. It also holds a small bank of working configuration registers, written from a serial-port decoder. When an active-low power-down pin is released, it can refill those registers from an internal nonvolatile image. It runs five programmable output dividers that always restart together.

Two low-power modes switch off the same hardware. Leaving power-down through the pin can reload the configuration, but only when the serial load-enable level is high at the release edge. Leaving sleep, which a control-register bit selects, never reloads anything. The sync mode holds every divider at zero and turns off the buffers while the PLL keeps running. It is entered from a control bit, from an active-low pin, or automatically for a short window after any divider register is written.

Top module: `pwrsync_top`

## Requirements
- R1: After reset the mode is normal (`mode` = 0), `pllEn`, `divEn` and `bufEn` are 1, `cfgBusy` is 0, register 8 reads 0x0180 and divider register 0 reads 0.
- R2: While the synchronised `pdPinN` is low, the mode is power-down (`mode` = 3) and `pllEn`, `divEn` and `bufEn` are 0. Serial writes still update the registers.
- R3: A rising edge of the synchronised `pdPinN`, seen while the synchronised `loadEn` is high, sets `cfgBusy` for exactly 16 cycles and copies the image into all 16 registers. The image is: word i (i < 5) = i+2, word 8 = 0x0180, and any other word i = 0x5A00 | i. While `cfgBusy` is high the mode is sync (`mode` = 1).
- R4: A power-down release with `loadEn` low starts no copy. `cfgBusy` stays 0 and the registers keep their values.
- R5: Register 8 bit 7 low selects sleep (`mode` = 2), with all three enables 0. Setting it high again leaves sleep without any copy.
- R6: Register 8 bit 8 low or `syncPinN` low selects sync (`mode` = 1), with `pllEn` = 1 and `divEn` = `bufEn` = 0. Sync ends only when both are high.
- R7: Priority is power-down, then sleep, then sync, then normal.
- R8: Divider k ticks (`divTick[k]` high for one cycle) every N cycles, where N is the low 8 bits of register k. A value of 0 behaves as 1.
- R9: On the first cycle after sync ends, every `divTick` bit is 1.
- R10: An accepted write to registers 0 to 4 holds `divEn` low for exactly the two cycles after the write edge. `divEn` is high again in the third cycle.
- R11: Serial writes presented while `cfgBusy` is high are ignored.
- R12: A write to a register outside 0 to 4 does not drop `divEn`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rstN | input | 1 | Asynchronous active-low reset |
| pdPinN | input | 1 | Power-down pin, active low, asynchronous |
| syncPinN | input | 1 | Sync pin, active low, asynchronous |
| loadEn | input | 1 | Serial load-enable level, asynchronous |
| wrEn | input | 1 | Register write strobe from the serial decoder |
| wrAddr | input | 4 | Register write address |
| wrData | input | 16 | Register write data |
| rdAddr | input | 4 | Register read address |
| rdData | output | 16 | Register read data (combinational) |
| pllEn | output | 1 | PLL enable |
| divEn | output | 1 | Output-divider run enable |
| bufEn | output | 1 | Output-buffer enable |
| divTick | output | 5 | Per-divider one-cycle tick |
| cfgBusy | output | 1 | Configuration copy in progress |
| mode | output | 2 | 0 normal, 1 sync, 2 sleep, 3 power-down |

## Verification
The hardest case to reach from the ports is a serial write that arrives while the copy is running and targets a register the copy has already passed. Only such a write reveals whether busy-time writes are really dropped, because an earlier slot would simply be overwritten by the copy. The bench releases power-down with load-enable high and counts busy cycles. Late in the copy it writes a divider register that was copied early, and then reads it back against the image value.

// File: rtl/pwrsync_pkg.sv
package pwrsync_pkg;
  localparam int CFG_WORDS   = 16;
  localparam int CFG_ADDR_W  = $clog2(CFG_WORDS);
  localparam int WORD_W      = 16;
  localparam int DIV_COUNT   = 5;
  localparam int DIV_W       = 8;
  localparam int CTRL_ADDR   = 8;
  localparam int SLEEP_BIT   = 7;
  localparam int SYNC_BIT    = 8;
  localparam int AUTO_HOLD   = 2;
  localparam int SYNC_STAGES = 2;
  localparam logic [WORD_W-1:0] CTRL_IDLE = WORD_W'((1 << SLEEP_BIT) | (1 << SYNC_BIT));

  typedef enum logic [1:0] {
    MODE_NORMAL = 2'd0,
    MODE_SYNC   = 2'd1,
    MODE_SLEEP  = 2'd2,
    MODE_PD     = 2'd3
  } mode_t;

  typedef struct packed {
    logic                  copyWe;
    logic [CFG_ADDR_W-1:0] copyIdx;
    logic                  wrAccept;
    logic                  divRun;
  } ctrlStrobes_t;

  // Nonvolatile image content, computed per word
  function automatic logic [WORD_W-1:0] nvWord(input int idx);
    if (idx < DIV_COUNT)       return WORD_W'(idx + 2);
    else if (idx == CTRL_ADDR) return CTRL_IDLE;
    else                       return WORD_W'(16'h5A00 | idx);
  endfunction
endpackage

// File: rtl/pwrsync_ctrl.sv
module pwrsync_ctrl
  import pwrsync_pkg::*;
(
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  pdPinN,
  input  logic                  syncPinN,
  input  logic                  loadEn,
  input  logic                  wrEn,
  input  logic [CFG_ADDR_W-1:0] wrAddr,
  input  logic                  sleepN,
  input  logic                  syncN,
  output ctrlStrobes_t          strobes,
  output mode_t                 mode,
  output logic                  busy,
  output logic                  pllEn,
  output logic                  bufEn
);
  localparam int HOLD_W = $clog2(AUTO_HOLD + 1);
  localparam logic [CFG_ADDR_W-1:0] LAST_IDX = CFG_ADDR_W'(CFG_WORDS - 1);
  localparam logic [CFG_ADDR_W-1:0] DIV_LIMIT = CFG_ADDR_W'(DIV_COUNT);

  logic [SYNC_STAGES-1:0] pdPipe, syncPipe, ldPipe;
  logic pdSync, pdSyncQ, syncPinSync, loadAtRise, pdRise;
  logic [CFG_ADDR_W-1:0] copyIdx;
  logic [HOLD_W-1:0] autoCnt;
  logic wrAccept, divWrite;

  // Pin synchronisers
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pdPipe   <= '1;
      syncPipe <= '1;
      ldPipe   <= '0;
      pdSyncQ  <= 1'b1;
    end else begin
      pdPipe   <= {pdPipe[SYNC_STAGES-2:0], pdPinN};
      syncPipe <= {syncPipe[SYNC_STAGES-2:0], syncPinN};
      ldPipe   <= {ldPipe[SYNC_STAGES-2:0], loadEn};
      pdSyncQ  <= pdSync;
    end
  end

  assign pdSync      = pdPipe[SYNC_STAGES-1];
  assign syncPinSync = syncPipe[SYNC_STAGES-1];
  assign loadAtRise  = ldPipe[SYNC_STAGES-1];
  assign pdRise      = pdSync & ~pdSyncQ;
  assign wrAccept    = wrEn & ~busy;
  assign divWrite    = wrAccept && (wrAddr < DIV_LIMIT);

  // Configuration copy sequencer
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busy    <= 1'b0;
      copyIdx <= '0;
    end else if (pdRise && loadAtRise) begin
      busy    <= 1'b1;
      copyIdx <= '0;
    end else if (busy) begin
      copyIdx <= copyIdx + 1'b1;
      if (copyIdx == LAST_IDX) busy <= 1'b0;
    end
  end

  // Automatic sync window after a divider write
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                autoCnt <= '0;
    else if (divWrite)        autoCnt <= HOLD_W'(AUTO_HOLD);
    else if (autoCnt != '0)   autoCnt <= autoCnt - 1'b1;
  end

  always_comb begin
    if (!pdSync)                                              mode = MODE_PD;
    else if (!sleepN)                                         mode = MODE_SLEEP;
    else if (!syncN || !syncPinSync || autoCnt != '0 || busy) mode = MODE_SYNC;
    else                                                      mode = MODE_NORMAL;
  end

  assign pllEn = (mode == MODE_NORMAL) || (mode == MODE_SYNC);
  assign bufEn = (mode == MODE_NORMAL);

  always_comb begin
    strobes.copyWe   = busy;
    strobes.copyIdx  = copyIdx;
    strobes.wrAccept = wrAccept;
    strobes.divRun   = (mode == MODE_NORMAL);
  end

  AST_COPY_NEEDS_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(loadAtRise)) else $error("copy without load-enable"); // R3
  AST_PD_OVERRIDES: assert property (@(posedge clk) disable iff (!rstN)
    !pdSync |-> (!pllEn && !bufEn && !strobes.divRun)) else $error("power-down leak"); // R2
  AST_SLEEP_OVER_SYNC: assert property (@(posedge clk) disable iff (!rstN)
    (pdSync && !sleepN) |-> !pllEn) else $error("sleep lost to sync"); // R7
  AST_AUTO_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    divWrite |=> !strobes.divRun) else $error("divider write did not hold"); // R10
endmodule

// File: rtl/pwrsync_datapath.sv
module pwrsync_datapath
  import pwrsync_pkg::*;
(
  input  logic                  clk,
  input  logic                  rstN,
  input  ctrlStrobes_t          strobes,
  input  logic [CFG_ADDR_W-1:0] wrAddr,
  input  logic [WORD_W-1:0]     wrData,
  input  logic [CFG_ADDR_W-1:0] rdAddr,
  output logic [WORD_W-1:0]     rdData,
  output logic                  sleepN,
  output logic                  syncN,
  output logic [DIV_COUNT-1:0]  divTick
);
  logic [WORD_W-1:0] workRegs [CFG_WORDS];
  logic [WORD_W-1:0] nvStore  [CFG_WORDS];

  for (genvar g = 0; g < CFG_WORDS; g++) begin : gNv
    assign nvStore[g] = nvWord(g);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < CFG_WORDS; i++)
        workRegs[i] <= (i == CTRL_ADDR) ? CTRL_IDLE : '0;
    end else if (strobes.copyWe) begin
      workRegs[strobes.copyIdx] <= nvStore[strobes.copyIdx];
    end else if (strobes.wrAccept) begin
      workRegs[wrAddr] <= wrData;
    end
  end

  assign rdData = workRegs[rdAddr];
  assign sleepN = workRegs[CTRL_ADDR][SLEEP_BIT];
  assign syncN  = workRegs[CTRL_ADDR][SYNC_BIT];

  for (genvar d = 0; d < DIV_COUNT; d++) begin : gDiv
    logic [DIV_W-1:0] divVal, effDiv, divCnt;
    assign divVal = workRegs[d][DIV_W-1:0];
    assign effDiv = (divVal == '0) ? DIV_W'(1) : divVal;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                       divCnt <= '0;
      else if (!strobes.divRun)        divCnt <= '0;
      else if (divCnt >= effDiv - 1'b1) divCnt <= '0;
      else                             divCnt <= divCnt + 1'b1;
    end

    assign divTick[d] = strobes.divRun && (divCnt == '0);

    AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rstN)
      strobes.divRun |-> (divCnt < effDiv)) else $error("divider count out of range"); // R8
  end

  AST_ALIGNED_START: assert property (@(posedge clk) disable iff (!rstN)
    $rose(strobes.divRun) |-> (&divTick)) else $error("dividers not aligned"); // R9
endmodule

// File: rtl/pwrsync_top.sv
module pwrsync_top
  import pwrsync_pkg::*;
(
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  pdPinN,
  input  logic                  syncPinN,
  input  logic                  loadEn,
  input  logic                  wrEn,
  input  logic [CFG_ADDR_W-1:0] wrAddr,
  input  logic [WORD_W-1:0]     wrData,
  input  logic [CFG_ADDR_W-1:0] rdAddr,
  output logic [WORD_W-1:0]     rdData,
  output logic                  pllEn,
  output logic                  divEn,
  output logic                  bufEn,
  output logic [DIV_COUNT-1:0]  divTick,
  output logic                  cfgBusy,
  output logic [1:0]            mode
);
  ctrlStrobes_t strobes;
  mode_t        modeInt;
  logic         sleepN, syncN;

  pwrsync_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .pdPinN(pdPinN), .syncPinN(syncPinN), .loadEn(loadEn),
    .wrEn(wrEn), .wrAddr(wrAddr), .sleepN(sleepN), .syncN(syncN),
    .strobes(strobes), .mode(modeInt), .busy(cfgBusy), .pllEn(pllEn), .bufEn(bufEn)
  );

  pwrsync_datapath u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .wrAddr(wrAddr), .wrData(wrData),
    .rdAddr(rdAddr), .rdData(rdData), .sleepN(sleepN), .syncN(syncN), .divTick(divTick)
  );

  assign divEn = strobes.divRun;
  assign mode  = modeInt;
endmodule

// File: tb/pwrsync_top_tb.sv
module pwrsync_top_tb;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic pdPinN = 1'b1, syncPinN = 1'b1, loadEn = 1'b0, wrEn = 1'b0;
  logic [3:0] wrAddr = '0, rdAddr = '0;
  logic [15:0] wrData = '0;
  logic [15:0] rdData;
  logic pllEn, divEn, bufEn, cfgBusy;
  logic [4:0] divTick;
  logic [1:0] mode;
  int total = 0, bad = 0;
  logic done = 1'b0;

  always #5 clk = ~clk;

  pwrsync_top u_dut (
    .clk(clk), .rstN(rstN), .pdPinN(pdPinN), .syncPinN(syncPinN), .loadEn(loadEn),
    .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData), .rdAddr(rdAddr), .rdData(rdData),
    .pllEn(pllEn), .divEn(divEn), .bufEn(bufEn), .divTick(divTick), .cfgBusy(cfgBusy),
    .mode(mode)
  );

  function automatic logic [15:0] imageWord(input int i);
    if (i < 5) return 16'(i + 2);
    else if (i == 8) return 16'h0180;
    else return 16'(16'h5A00 | i);
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step(input int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      #1;
    end
  endtask

  task automatic wrReg(input logic [3:0] a, input logic [15:0] d);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    step();
    wrEn = 1'b0;
  endtask

  task automatic rdReg(input logic [3:0] a, output logic [15:0] d);
    rdAddr = a;
    #1;
    d = rdData;
  endtask

  task automatic tReset();
    logic [15:0] v;
    chk("R1 mode", 32'(mode), 0);
    chk("R1 enables", {pllEn, divEn, bufEn}, 3'b111);
    chk("R1 busy", 32'(cfgBusy), 0);
    rdReg(4'd8, v); chk("R1 reg8", 32'(v), 32'h0180);
    rdReg(4'd0, v); chk("R1 reg0", 32'(v), 0);
  endtask

  task automatic tDividers();
    logic [7:0] vals [5];
    int eff;
    vals[0] = 8'd0; vals[1] = 8'd1; vals[2] = 8'd3; vals[3] = 8'd4; vals[4] = 8'd7;
    for (int k = 0; k < 5; k++) wrReg(4'(k), {8'h00, vals[k]});
    chk("R10 hold cycle 1", 32'(divEn), 0);
    step();
    chk("R10 hold cycle 2", 32'(divEn), 0);
    step();
    chk("R10 release", 32'(divEn), 1);
    chk("R9 aligned after auto sync", 32'(divTick), 5'h1F);
    for (int c = 0; c < 24; c++) begin
      for (int k = 0; k < 5; k++) begin
        eff = (vals[k] == 0) ? 1 : int'(vals[k]);
        chk("R8 tick pattern", 32'(divTick[k]), 32'((c % eff) == 0));
      end
      step();
    end
  endtask

  task automatic tOtherWrite();
    wrReg(4'd12, 16'h00AA);
    for (int c = 0; c < 3; c++) begin
      chk("R12 divEn stays", 32'(divEn), 1);
      step();
    end
  endtask

  task automatic tPinSync();
    int waitCnt = 0;
    syncPinN = 1'b0;
    step(3);
    chk("R6 pin sync mode", 32'(mode), 1);
    chk("R6 pin sync enables", {pllEn, divEn, bufEn}, 3'b100);
    wrReg(4'd8, 16'h0080);
    syncPinN = 1'b1;
    step(3);
    chk("R6 bit still holds", 32'(mode), 1);
    wrReg(4'd8, 16'h0180);
    while (!divEn && waitCnt < 10) begin step(); waitCnt++; end
    chk("R6 sync ends", 32'(mode), 0);
    chk("R9 aligned after pin sync", 32'(divTick), 5'h1F);
  endtask

  task automatic tSleepPriority();
    logic [15:0] v;
    wrReg(4'd10, 16'h1111);
    wrReg(4'd8, 16'h0100);
    chk("R5 sleep mode", 32'(mode), 2);
    chk("R5 sleep enables", {pllEn, divEn, bufEn}, 3'b000);
    syncPinN = 1'b0;
    step(3);
    chk("R7 sleep over sync", 32'(mode), 2);
    pdPinN = 1'b0;
    step(3);
    chk("R7 pd over sleep", 32'(mode), 3);
    loadEn = 1'b0;
    pdPinN = 1'b1;
    step(3);
    chk("R7 back to sleep", 32'(mode), 2);
    wrReg(4'd8, 16'h0180);
    chk("R7 sync after sleep", 32'(mode), 1);
    chk("R5 no copy on sleep exit", 32'(cfgBusy), 0);
    rdReg(4'd10, v); chk("R5 reg kept", 32'(v), 32'h1111);
    syncPinN = 1'b1;
    step(3);
    chk("R6 both high normal", 32'(mode), 0);
  endtask

  task automatic tNoLoad();
    logic [15:0] v;
    int seen = 0;
    wrReg(4'd10, 16'h2222);
    loadEn = 1'b0;
    pdPinN = 1'b0;
    step(3);
    pdPinN = 1'b1;
    for (int c = 0; c < 20; c++) begin
      if (cfgBusy) seen++;
      step();
    end
    chk("R4 no busy", 32'(seen), 0);
    rdReg(4'd10, v); chk("R4 reg unchanged", 32'(v), 32'h2222);
    chk("R4 normal", 32'(mode), 0);
  endtask

  task automatic tCopy();
    logic [15:0] v;
    int busyLen = 0, waitCnt = 0;
    pdPinN = 1'b0;
    step(3);
    chk("R2 pd mode", 32'(mode), 3);
    chk("R2 pd enables", {pllEn, divEn, bufEn}, 3'b000);
    wrReg(4'd10, 16'h1234);
    rdReg(4'd10, v); chk("R2 write in pd", 32'(v), 32'h1234);
    loadEn = 1'b1;
    pdPinN = 1'b1;
    while (!cfgBusy && waitCnt < 10) begin step(); waitCnt++; end
    chk("R3 busy rose", 32'(cfgBusy), 1);
    while (cfgBusy && busyLen < 40) begin
      if (busyLen == 0) chk("R3 sync while busy", 32'(mode), 1);
      if (busyLen == 13) begin
        wrReg(4'd1, 16'hBEEF);
        busyLen++;
      end else begin
        step();
        busyLen++;
      end
    end
    chk("R3 busy length", 32'(busyLen), 16);
    for (int i = 0; i < 16; i++) begin
      rdReg(4'(i), v);
      chk((i == 1) ? "R11 busy write ignored" : "R3 image word", 32'(v), 32'(imageWord(i)));
    end
    loadEn = 1'b0;
    step();
    chk("R3 normal after copy", 32'(mode), 0);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    step(3);
    rstN = 1'b1;
    step(2);
    tReset();
    tDividers();
    tOtherWrite();
    tPinSync();
    tSleepPriority();
    tNoLoad();
    tCopy();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule